// File: doc/BRIEF.md
# Four-Bit Character Display Write Controller

This block writes commands and characters into a character display module whose data path is narrowed to four lines. A producer hands over one byte at a time on a valid/ready handshake, together with a tag that marks the byte as a command or as character data. The controller puts the upper half of the byte on the four data lines, raises the enable line for a set number of clock cycles, and drops it so the display takes the value on that falling edge. It then does the same with the lower half. The read/write line never leaves the write level.

After each byte the controller waits out the display's execution time before it takes the next one. The clear command (0x01) needs a much longer wait than any other byte. After reset, the controller first waits for the display's supply to settle. It then issues, on its own, the four-bit two-line function set (0x28), display-and-cursor-on (0x0E) and clear (0x01). Only then does it offer ready to the producer. A producer that wants the cursor at the start of the first line sends command 0x80 like any other byte.

Top module: `lcd4_writer`

## Requirements
- R1: `lcd_rs` is 0 while the nibbles of a command byte are strobed and 1 while the nibbles of a character data byte are strobed (`in_is_data` = 1 means data).
- R2: `lcd_rw` is 0 at all times.
- R3: Each byte produces exactly two falling edges of `lcd_en`. At the first, `lcd_d` holds bits 7:4 of the byte; at the second, it holds bits 3:0.
- R4: `lcd_d` and `lcd_rs` stay unchanged for at least `SETUP_CYC` cycles before `lcd_en` rises, and for as long as `lcd_en` stays high.
- R5: Each enable pulse is high for exactly `PULSE_CYC` clock cycles.
- R6: After reset, no enable pulse starts before `PWRUP_WAIT` cycles have passed. The first three bytes strobed are the commands 0x28, 0x0E and 0x01, in that order, and `in_ready` stays 0 until they are done.
- R7: `in_ready` drops in the cycle after a byte is accepted (`in_valid` and `in_ready` both high at a clock edge). It stays 0 until that byte's execution wait ends, and `lcd_en` is never high while `in_ready` is 1.
- R8: Between the last enable fall of a byte and the rise of `in_ready`, at least `LONG_WAIT` cycles pass for the command 0x01. For every other command and for all data bytes, at least `SHORT_WAIT` cycles pass. No more than the wait plus `HOLD_CYC` + 4 cycles pass in either case.
- R9: `in_valid` while `in_ready` is 0 is ignored and produces no enable pulse.
- R10: While reset is held, `lcd_en` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Controller takes a byte at this edge |
| in_byte | input | 8 | Byte to write |
| in_is_data | input | 1 | 1 = character data, 0 = command |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write to the display, held at write |
| lcd_en | output | 1 | Enable strobe; the display latches on its fall |
| lcd_d | output | 4 | Upper four data lines of the display |

## Verification
A byte shows up at the display pins over several cycles rather than in one. Its first nibble is latched after `SETUP_CYC` + `PULSE_CYC` cycles, its second after twice that plus `HOLD_CYC`. `in_ready` returns about `HOLD_CYC` + wait + 1 cycles after the second fall. Because of this, the bench does not sample a fixed cycle. It watches the pins on every falling clock edge and records each latched nibble together with its register select value. Alongside, it measures the setup run, the pulse width and the gap from the last fall to ready. After each byte it waits for ready plus one more sample before comparing the two new records and the gap with its own expected values. Widths are compared exactly. Waits are compared against the window stated in R8.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;
  typedef enum logic [1:0] {TOP_EXEC, TOP_IDLE, TOP_SEND} top_st_e;
  typedef enum logic [1:0] {SB_IDLE, SB_SETUP, SB_HIGH, SB_HOLD} stb_st_e;

  localparam int BOOT_LEN = 3;

  // power-up command list: 4-bit two-line, display+cursor on, clear
  function automatic logic [7:0] boot_cmd(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h28;
      2'd1:    return 8'h0E;
      default: return 8'h01;
    endcase
  endfunction

  // upper half goes out first
  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic second);
    return second ? b[3:0] : b[7:4];
  endfunction

  function automatic int unsigned exec_wait(input logic [7:0] b, input logic is_data,
                                            input int unsigned short_w, input int unsigned long_w);
    return (!is_data && b == 8'h01) ? long_w : short_w;
  endfunction
endpackage

// File: rtl/lcd4_delay_timer.sv
module lcd4_delay_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= CW'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/lcd4_nibble_strobe.sv
module lcd4_nibble_strobe
  import lcd4_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_byte,
  input  logic       start_rs,
  output logic       done,
  output logic       lcd_en,
  output logic       lcd_rs,
  output logic [3:0] lcd_d
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int SW = $clog2(MAXC + 1);

  stb_st_e       st_q;
  logic [SW-1:0] cnt_q;
  logic          second_q;
  logic [7:0]    byte_q;
  logic          rs_q;
  logic          cnt_end;

  assign cnt_end = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SB_IDLE; cnt_q <= '0; second_q <= 1'b0; byte_q <= '0; rs_q <= 1'b0;
    end else begin
      case (st_q)
        SB_IDLE: if (start) begin
          byte_q <= start_byte; rs_q <= start_rs; second_q <= 1'b0;
          st_q <= SB_SETUP; cnt_q <= SW'(SETUP_CYC - 1);
        end
        SB_SETUP: if (cnt_end) begin st_q <= SB_HIGH; cnt_q <= SW'(PULSE_CYC - 1); end
                  else cnt_q <= cnt_q - 1'b1;
        SB_HIGH:  if (cnt_end) begin st_q <= SB_HOLD; cnt_q <= SW'(HOLD_CYC - 1); end
                  else cnt_q <= cnt_q - 1'b1;
        SB_HOLD:  if (cnt_end) begin
                    if (!second_q) begin
                      second_q <= 1'b1; st_q <= SB_SETUP; cnt_q <= SW'(SETUP_CYC - 1);
                    end else st_q <= SB_IDLE;
                  end else cnt_q <= cnt_q - 1'b1;
        default:  st_q <= SB_IDLE;
      endcase
    end
  end

  assign done   = (st_q == SB_HOLD) && cnt_end && second_q;
  assign lcd_en = (st_q == SB_HIGH);
  assign lcd_rs = rs_q;
  assign lcd_d  = pick_nibble(byte_q, second_q);

  p_setup_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> ($stable(lcd_d) && $stable(lcd_rs)));
  p_high_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_d) && $stable(lcd_rs)));
endmodule

// File: rtl/lcd4_writer.sv
module lcd4_writer
  import lcd4_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 4,
  parameter int HOLD_CYC   = 2,
  parameter int SHORT_WAIT = 40,
  parameter int LONG_WAIT  = 200,
  parameter int PWRUP_WAIT = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [3:0] lcd_d
);
  localparam int MAXW0 = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int MAXW  = (MAXW0 > PWRUP_WAIT) ? MAXW0 : PWRUP_WAIT;
  localparam int CW    = $clog2(MAXW + 1);

  top_st_e       st_q;
  logic [1:0]    boot_idx_q;
  logic [7:0]    cur_byte_q;
  logic          cur_data_q;
  logic          boot_pending, tmr_expired, tmr_load, stb_done, stb_start, start_data;
  logic [7:0]    start_byte;
  logic [CW-1:0] tmr_val;

  assign boot_pending = (boot_idx_q < 2'(BOOT_LEN));
  assign in_ready     = (st_q == TOP_IDLE);
  assign lcd_rw       = 1'b0;
  assign tmr_load     = (st_q == TOP_SEND) && stb_done;
  assign tmr_val      = CW'(exec_wait(cur_byte_q, cur_data_q, SHORT_WAIT, LONG_WAIT));

  always_comb begin
    stb_start  = 1'b0;
    start_byte = in_byte;
    start_data = in_is_data;
    if (st_q == TOP_EXEC && tmr_expired && boot_pending) begin
      stb_start  = 1'b1;
      start_byte = boot_cmd(boot_idx_q);
      start_data = 1'b0;
    end else if (st_q == TOP_IDLE && in_valid) begin
      stb_start  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= TOP_EXEC; boot_idx_q <= '0; cur_byte_q <= '0; cur_data_q <= 1'b0;
    end else begin
      case (st_q)
        TOP_EXEC: if (tmr_expired) begin
          if (boot_pending) begin
            cur_byte_q <= start_byte; cur_data_q <= 1'b0;
            boot_idx_q <= boot_idx_q + 1'b1; st_q <= TOP_SEND;
          end else st_q <= TOP_IDLE;
        end
        TOP_IDLE: if (in_valid) begin
          cur_byte_q <= in_byte; cur_data_q <= in_is_data; st_q <= TOP_SEND;
        end
        TOP_SEND: if (stb_done) st_q <= TOP_EXEC;
        default:  st_q <= TOP_EXEC;
      endcase
    end
  end

  lcd4_nibble_strobe #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(stb_start), .start_byte(start_byte), .start_rs(start_data),
    .done(stb_done), .lcd_en(lcd_en), .lcd_rs(lcd_rs), .lcd_d(lcd_d));

  lcd4_delay_timer #(.CW(CW), .RST_VAL(PWRUP_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired));

  // observation: cycles since enable last fell, and the wait last requested
  logic [CW:0]   gap_q;
  logic [CW-1:0] need_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin gap_q <= '0; need_q <= '0; end
    else begin
      if (lcd_en) gap_q <= '0;
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
      if (tmr_load) need_q <= tmr_val;
    end
  end

  p_accept_drops_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_no_en_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !lcd_en);
  p_wait_met_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (gap_q >= {1'b0, need_q}));
  p_boot_blocks_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pending |-> !in_ready);
endmodule

// File: tb/lcd4_writer_bench.sv
module lcd4_writer_bench;
  localparam int SETUP = 2, PULSE = 4, HOLD = 2, SHORTW = 40, LONGW = 200, PWRUP = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_data = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, lcd_rs, lcd_rw, lcd_en;
  logic [3:0] lcd_d;

  always #2.5 clk = ~clk;

  lcd4_writer #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
                .SHORT_WAIT(SHORTW), .LONG_WAIT(LONGW), .PWRUP_WAIT(PWRUP)) u_lcd4_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .in_is_data(in_is_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_d(lcd_d));

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tb_wait(input logic [7:0] b, input bit isd);
    if (!isd && b == 8'h01) return LONGW;
    return SHORTW;
  endfunction

  // pin monitor
  logic [4:0] cap [0:511];
  int ncap = 0, last_gap = 0, gap = 0, hi_cnt = 0, stable = 0, rw_bad = 0, cyc = 0, first_rise = -1;
  logic prev_en = 0, prev_rs = 0, prev_rdy = 0;
  logic [3:0] prev_d = '0, rise_d = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (lcd_rw !== 1'b0) rw_bad++;
      if (lcd_d !== prev_d || lcd_rs !== prev_rs) stable = 0; else stable++;
      if (lcd_en && !prev_en) begin
        chk(stable >= SETUP, "R4 setup", stable, SETUP);
        rise_d = lcd_d;
        if (first_rise < 0) first_rise = cyc;
      end
      if (lcd_en) hi_cnt++;
      if (!lcd_en && prev_en) begin
        chk(hi_cnt == PULSE, "R5 pulse width", hi_cnt, PULSE);
        chk(lcd_d == rise_d, "R4 data held while high", lcd_d, rise_d);
        if (ncap < 512) cap[ncap] = {lcd_rs, lcd_d};
        ncap++; hi_cnt = 0; gap = 0;
      end else if (!lcd_en) gap++;
      if (in_ready && !prev_rdy) last_gap = gap;
      prev_en = lcd_en; prev_rs = lcd_rs; prev_d = lcd_d; prev_rdy = in_ready;
    end
  end

  task automatic check_byte(input int n0, input logic [7:0] b, input bit isd, input string tag);
    int w = tb_wait(b, isd);
    chk(ncap == n0 + 2, {tag, " R3/R9 two strobes per byte"}, ncap - n0, 2);
    chk(cap[n0] == {isd, b[7:4]}, {tag, " R1/R3 upper nibble first"}, cap[n0], {isd, b[7:4]});
    chk(cap[n0 + 1] == {isd, b[3:0]}, {tag, " R1/R3 lower nibble second"}, cap[n0 + 1], {isd, b[3:0]});
    chk(last_gap >= w && last_gap <= w + HOLD + 4, {tag, " R8 execution wait"}, last_gap, w);
  endtask

  task automatic send(input logic [7:0] b, input bit isd, input bit garbage);
    int n0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    n0 = ncap;
    in_valid = 1; in_byte = b; in_is_data = isd;
    @(negedge clk);
    in_valid = 0;
    chk(!in_ready, "R7 ready drops after accept", in_ready, 0);
    if (garbage) begin
      for (int k = 0; k < 3; k++) begin
        in_valid = 1; in_byte = 8'($urandom); in_is_data = 1'($urandom);
        @(negedge clk);
      end
      in_valid = 0; in_byte = b; in_is_data = isd;
    end
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    check_byte(n0, b, isd, garbage ? "busy-valid" : "byte");
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(!lcd_en && !in_ready, "R10 reset state", {lcd_en, in_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    // R6 boot sequence
    chk(first_rise - 3 >= PWRUP, "R6 power-up wait", first_rise - 3, PWRUP);
    chk(ncap == 6, "R6 boot strobe count", ncap, 6);
    chk(cap[0] == 5'h02 && cap[1] == 5'h08, "R6 function set 0x28", {cap[0], cap[1]}, 10'h048);
    chk(cap[2] == 5'h00 && cap[3] == 5'h0E, "R6 display on 0x0E", {cap[2], cap[3]}, 10'h00E);
    chk(cap[4] == 5'h00 && cap[5] == 5'h01, "R6 clear 0x01", {cap[4], cap[5]}, 10'h001);
    chk(last_gap >= LONGW && last_gap <= LONGW + HOLD + 4, "R6/R8 boot clear wait", last_gap, LONGW);
    // directed corners
    send(8'h01, 0, 0);   // clear: long wait
    send(8'h01, 1, 0);   // data 0x01: short wait
    send(8'h80, 0, 0);   // cursor home line 1
    send(8'h0E, 0, 1);   // valid while busy ignored (R9)
    send(8'h41, 1, 0);
    send(8'hFF, 1, 0);
    send(8'h00, 0, 0);
    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic [7:0] rb = 8'($urandom);
      bit rd = 1'($urandom);
      if (($urandom % 8) == 0) begin rb = 8'h01; rd = 0; end
      send(rb, rd, 1'($urandom % 4 == 0));
    end
    chk(rw_bad == 0, "R2 read/write held low", rw_bad, 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule